// File: doc/BRIEF.md
# Endpoint FIFO Command and Status Register

This block is a 12-bit register through which a microcontroller steers and watches the FIFO of the currently selected USB endpoint. Some bits are control bits that firmware owns. The others are status flags that the serial engine sets, each with its own clearing rule:

- one clears only when firmware writes zero to it;
- one clears when the MCU reads the FIFO;
- one holds until fresh data arrives;
- some simply follow an engine level signal.

Firmware takes the FIFO by raising the claim bit. It then marks the end of a transfer by the direction in which it toggles the direction bit. The block turns these register writes into one-cycle handshake pulses for the FIFO logic. It also turns a flush request into a flush pulse and an under-run report to the host. Finally, it gates NAK and isochronous pipe events into interrupt pulses.

Bit layout, MSB to LSB:

| Bit | Name | Access |
|-----|------|--------|
| 11 | err | sticky |
| 10 | tok_idle | read-only |
| 9 | nak_mask | read/write |
| 8 | claim | read/write |
| 7 | dir | read/write |
| 6 | flush | read/write |
| 5 | iso_in_en | read/write |
| 4 | iso_out_en | read/write |
| 3 | setup | hardware/firmware |
| 2 | ready | read-only |
| 1 | zlen | read-only |
| 0 | reserved | reads 0 |

Top module: `ep_csr`

## Requirements
- R1: Any clock edge with `rst_n` low or `bus_reset` high clears all 12 register bits and every pulse output. `rd_data` reads 0 after that edge.
- R2: Bit 11 (err) sets the edge after `ev_err`. It stays set until a write with bit 11 = 0. A write with bit 11 = 1 never sets it. When `ev_err` and a clearing write fall in the same cycle, the flag stays set.
- R3: Bit 10 shows the inverse of `ev_tok_active` and bit 2 shows `ev_fifo_ready`, each one cycle late. Writes to bits 10, 2, 1 and 0 are ignored, and bit 0 always reads 0.
- R4: `nak_irq` pulses the cycle after `ev_nak_sent` only when bit 9 (nak_mask) is 0.
- R5: Bits 9 to 4 hold the last written value. `fifo_req` equals bit 8 and `fifo_dir_wr` equals bit 7.
- R6: `xfer_end_wr` pulses for one cycle after a write that takes bit 7 from 1 to 0 while bit 8 is 1.
- R7: `xfer_end_rd` pulses for one cycle after a write that takes bit 7 from 0 to 1 while bit 8 is 1.
- R8: `fifo_flush` pulses after a write that takes bit 6 from 0 to 1. This also arms an under-run state. While that state is armed, `host_in_req` gives a `force_tx_err` pulse one cycle later. A write-transfer end (R6) disarms it.
- R9: `iso_in_irq` pulses the cycle after `ev_iso_in` only if bit 5 is 1. `iso_out_irq` pulses the cycle after `ev_iso_out` only if bit 4 is 1.
- R10: Bit 3 (setup) sets on `ev_setup_rx` and clears on `ev_data_rx`. Otherwise it keeps its value or takes the written value. The priority is `ev_setup_rx` first, then `ev_data_rx`, then the write.
- R11: Bit 1 (zlen) sets on `ev_zlp_rx` and clears on `fifo_rd`. The set wins when both occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | USB bus reset, synchronous clear |
| wr_en | input | 1 | MCU register write strobe |
| wr_data | input | 12 | MCU write data |
| rd_data | output | 12 | Register read value |
| ev_err | input | 1 | CRC, PID or incomplete-token error event |
| ev_tok_active | input | 1 | Token packet in progress (level) |
| ev_nak_sent | input | 1 | NAK handshake sent to host |
| ev_setup_rx | input | 1 | Setup packet entered the FIFO |
| ev_data_rx | input | 1 | Non-setup data entered the FIFO |
| ev_zlp_rx | input | 1 | Zero-length packet received |
| ev_fifo_ready | input | 1 | FIFO ready (level) |
| ev_iso_in | input | 1 | Isochronous IN pipe event |
| ev_iso_out | input | 1 | Isochronous OUT pipe event |
| host_in_req | input | 1 | Host requests data from the FIFO |
| fifo_rd | input | 1 | MCU FIFO read strobe |
| fifo_req | output | 1 | FIFO claimed by the MCU |
| fifo_dir_wr | output | 1 | Current direction bit |
| xfer_end_wr | output | 1 | MCU write transfer finished (pulse) |
| xfer_end_rd | output | 1 | MCU read transfer finished (pulse) |
| fifo_flush | output | 1 | Flush the FIFO (pulse) |
| force_tx_err | output | 1 | Report under-run to the host (pulse) |
| nak_irq | output | 1 | NAK interrupt (pulse) |
| iso_in_irq | output | 1 | Isochronous IN interrupt (pulse) |
| iso_out_irq | output | 1 | Isochronous OUT interrupt (pulse) |

## Verification
The properties assume that every engine input is synchronous to `clk` and that each event is a single-cycle strobe. The exceptions are `ev_tok_active` and `ev_fifo_ready`, which are levels. The bench drives all inputs on the falling edge, so each strobe is held for exactly one rising edge. It returns every strobe to zero before it issues the next write. The checks on interrupts and end-of-transfer see each pulse alone, because no two writes that could each raise the same pulse are ever adjacent.

// File: rtl/ep_csr_pkg.sv
// Package: bit positions and derived masks of the endpoint FIFO
// command/status register. Assumes a 12-bit register layout.
package ep_csr_pkg;
    localparam int CSR_W    = 12;
    localparam int B_ERR    = 11;
    localparam int B_TOKN   = 10;
    localparam int B_NAKM   = 9;
    localparam int B_CLAIM  = 8;
    localparam int B_DIR    = 7;
    localparam int B_FLUSH  = 6;
    localparam int B_ISOI   = 5;
    localparam int B_ISOO   = 4;
    localparam int B_SETUP  = 3;
    localparam int B_RDY    = 2;
    localparam int B_ZLEN   = 1;
    localparam int CTRL_W   = B_NAKM - B_ISOO + 1;
    localparam int N_IRQ    = 3;
endpackage

// File: rtl/ep_csr_flags.sv
// Module: hardware-set status flags with their individual clear rules.
// Assumes single-cycle event strobes, except that tok_active and
// fifo_ready are levels. Bus reset and rst_n clear every flag.
module ep_csr_flags
    import ep_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             ev_err,
    input  logic             ev_tok_active,
    input  logic             ev_fifo_ready,
    input  logic             ev_setup_rx,
    input  logic             ev_data_rx,
    input  logic             ev_zlp_rx,
    input  logic             fifo_rd,
    output logic             err_q,
    output logic             tok_idle_q,
    output logic             ready_q,
    output logic             setup_q,
    output logic             zlen_q
);
    logic clr;
    assign clr = !rst_n || bus_reset;

    // Error flag: hardware set wins over a firmware write of zero.
    always_ff @(posedge clk) begin
        if (clr)                            err_q <= 1'b0;
        else if (ev_err)                    err_q <= 1'b1;
        else if (wr_en && !wr_data[B_ERR])  err_q <= 1'b0;
    end

    // Level status mirrors: token idle (inverted) and FIFO ready.
    always_ff @(posedge clk) begin
        if (clr) begin
            tok_idle_q <= 1'b0;
            ready_q    <= 1'b0;
        end else begin
            tok_idle_q <= !ev_tok_active;
            ready_q    <= ev_fifo_ready;
        end
    end

    // Setup marker: held until new data arrives; firmware may write it.
    always_ff @(posedge clk) begin
        if (clr)              setup_q <= 1'b0;
        else if (ev_setup_rx) setup_q <= 1'b1;
        else if (ev_data_rx)  setup_q <= 1'b0;
        else if (wr_en)       setup_q <= wr_data[B_SETUP];
    end

    // Zero-length marker: set by a ZLP, cleared by an MCU FIFO read.
    always_ff @(posedge clk) begin
        if (clr)            zlen_q <= 1'b0;
        else if (ev_zlp_rx) zlen_q <= 1'b1;
        else if (fifo_rd)   zlen_q <= 1'b0;
    end
endmodule

// File: rtl/ep_csr_ctrl.sv
// Module: firmware control bits plus the handshake that turns
// direction-bit toggles into end-of-transfer pulses, a flush pulse and
// the under-run report. Assumes writes arrive as single-cycle strobes.
module ep_csr_ctrl
    import ep_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wr_data,
    input  logic              host_in_req,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              xfer_end_wr,
    output logic              xfer_end_rd,
    output logic              fifo_flush,
    output logic              force_tx_err
);
    localparam int O_CLAIM = B_CLAIM - B_ISOO;
    localparam int O_DIR   = B_DIR - B_ISOO;
    localparam int O_FLUSH = B_FLUSH - B_ISOO;

    logic clr;
    logic end_wr_d, end_rd_d, flush_d;
    logic underrun_q;

    assign clr = !rst_n || bus_reset;

    // Decode the transfer-end and flush conditions of the current write.
    always_comb begin
        end_wr_d = wr_en && ctrl_q[O_CLAIM] && ctrl_q[O_DIR] && !wr_data[B_DIR];
        end_rd_d = wr_en && ctrl_q[O_CLAIM] && !ctrl_q[O_DIR] && wr_data[B_DIR];
        flush_d  = wr_en && !ctrl_q[O_FLUSH] && wr_data[B_FLUSH];
    end

    // Control bit storage written by firmware.
    always_ff @(posedge clk) begin
        if (clr)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data[B_NAKM:B_ISOO];
    end

    // One-cycle handshake pulses.
    always_ff @(posedge clk) begin
        if (clr) begin
            xfer_end_wr <= 1'b0;
            xfer_end_rd <= 1'b0;
            fifo_flush  <= 1'b0;
        end else begin
            xfer_end_wr <= end_wr_d;
            xfer_end_rd <= end_rd_d;
            fifo_flush  <= flush_d;
        end
    end

    // Under-run state: armed by a flush, disarmed by a refill transfer.
    always_ff @(posedge clk) begin
        if (clr)           underrun_q <= 1'b0;
        else if (flush_d)  underrun_q <= 1'b1;
        else if (end_wr_d) underrun_q <= 1'b0;
    end

    // Forced transmit error on each host read while under-run is armed.
    always_ff @(posedge clk) begin
        if (clr) force_tx_err <= 1'b0;
        else     force_tx_err <= host_in_req && underrun_q;
    end
endmodule

// File: rtl/ep_csr_irq.sv
// Module: gates N event strobes with their enables into registered
// one-cycle interrupt pulses. Assumes event strobes last one cycle.
module ep_csr_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_reset,
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // Register one gated interrupt line.
        always_ff @(posedge clk) begin
            if (!rst_n || bus_reset) irq[i] <= 1'b0;
            else                     irq[i] <= src[i] && en[i];
        end
    end
endmodule

// File: rtl/ep_csr.sv
// Module: top of the endpoint FIFO command/status register. It assembles
// the read value from the flag and control blocks and routes the
// interrupt gating. Assumes synchronous inputs and an active-low
// synchronous reset.
module ep_csr
    import ep_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data,
    input  logic             ev_err,
    input  logic             ev_tok_active,
    input  logic             ev_nak_sent,
    input  logic             ev_setup_rx,
    input  logic             ev_data_rx,
    input  logic             ev_zlp_rx,
    input  logic             ev_fifo_ready,
    input  logic             ev_iso_in,
    input  logic             ev_iso_out,
    input  logic             host_in_req,
    input  logic             fifo_rd,
    output logic             fifo_req,
    output logic             fifo_dir_wr,
    output logic             xfer_end_wr,
    output logic             xfer_end_rd,
    output logic             fifo_flush,
    output logic             force_tx_err,
    output logic             nak_irq,
    output logic             iso_in_irq,
    output logic             iso_out_irq
);
    logic              err_q, tok_idle_q, ready_q, setup_q, zlen_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [N_IRQ-1:0]  irq_src, irq_en, irq_out;

    ep_csr_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset    (bus_reset),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .ev_err       (ev_err),
        .ev_tok_active(ev_tok_active),
        .ev_fifo_ready(ev_fifo_ready),
        .ev_setup_rx  (ev_setup_rx),
        .ev_data_rx   (ev_data_rx),
        .ev_zlp_rx    (ev_zlp_rx),
        .fifo_rd      (fifo_rd),
        .err_q        (err_q),
        .tok_idle_q   (tok_idle_q),
        .ready_q      (ready_q),
        .setup_q      (setup_q),
        .zlen_q       (zlen_q)
    );

    ep_csr_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .host_in_req (host_in_req),
        .ctrl_q      (ctrl_q),
        .xfer_end_wr (xfer_end_wr),
        .xfer_end_rd (xfer_end_rd),
        .fifo_flush  (fifo_flush),
        .force_tx_err(force_tx_err)
    );

    // Interrupt sources and enables: NAK is enabled by a clear mask bit.
    always_comb begin
        irq_src = {ev_nak_sent, ev_iso_in, ev_iso_out};
        irq_en  = {!ctrl_q[B_NAKM-B_ISOO], ctrl_q[B_ISOI-B_ISOO], ctrl_q[0]};
    end

    ep_csr_irq #(.N(N_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_reset(bus_reset),
        .src      (irq_src),
        .en       (irq_en),
        .irq      (irq_out)
    );

    // Read value assembly; the reserved bit reads zero.
    always_comb begin
        rd_data = {err_q, tok_idle_q, ctrl_q, setup_q, ready_q, zlen_q, 1'b0};
    end

    assign fifo_req    = ctrl_q[B_CLAIM-B_ISOO];
    assign fifo_dir_wr = ctrl_q[B_DIR-B_ISOO];
    assign nak_irq     = irq_out[2];
    assign iso_in_irq  = irq_out[1];
    assign iso_out_irq = irq_out[0];
endmodule

// File: rtl/ep_csr_checks.sv
// Checker: temporal properties of ep_csr, bound to every instance.
module ep_csr_checks
    import ep_csr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_reset,
    input logic             wr_en,
    input logic [CSR_W-1:0] wr_data,
    input logic [CSR_W-1:0] rd_data,
    input logic             ev_err,
    input logic             ev_nak_sent,
    input logic             ev_zlp_rx,
    input logic             ev_fifo_ready,
    input logic             fifo_rd,
    input logic             xfer_end_wr,
    input logic             nak_irq
);
    assert_bus_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (rd_data == '0));

    assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && !bus_reset) |=> rd_data[B_ERR]);

    assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_ERR] && !bus_reset && !(wr_en && !wr_data[B_ERR])) |=> rd_data[B_ERR]);

    assert_ready_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_reset |=> (rd_data[B_RDY] == $past(ev_fifo_ready)));

    assert_nak_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[B_NAKM] |=> !nak_irq);

    assert_nak_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nak_sent && !rd_data[B_NAKM] && !bus_reset) |=> nak_irq);

    assert_write_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[B_CLAIM] && rd_data[B_DIR] && !wr_data[B_DIR] && !bus_reset)
        |=> xfer_end_wr);

    assert_zlen_read_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && !ev_zlp_rx) |=> !rd_data[B_ZLEN]);
endmodule

bind ep_csr ep_csr_checks u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_reset    (bus_reset),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .ev_err       (ev_err),
    .ev_nak_sent  (ev_nak_sent),
    .ev_zlp_rx    (ev_zlp_rx),
    .ev_fifo_ready(ev_fifo_ready),
    .fifo_rd      (fifo_rd),
    .xfer_end_wr  (xfer_end_wr),
    .nak_irq      (nak_irq)
);

// File: tb/ep_csr_test.sv
`timescale 1ns/1ps
// Bench: sweeps writes, control combinations and event patterns over
// ep_csr. Inputs change on the falling edge; outputs are sampled on
// the falling edge that follows the rising edge of interest.
module ep_csr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic ev_err = 0, ev_tok_active = 0, ev_nak_sent = 0, ev_setup_rx = 0;
    logic ev_data_rx = 0, ev_zlp_rx = 0, ev_fifo_ready = 0, ev_iso_in = 0;
    logic ev_iso_out = 0, host_in_req = 0, fifo_rd = 0;
    logic fifo_req, fifo_dir_wr, xfer_end_wr, xfer_end_rd, fifo_flush;
    logic force_tx_err, nak_irq, iso_in_irq, iso_out_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ep_csr uut (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] v);
        wr_en = 1'b1; wr_data = v; tick(); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic breset();
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        tick(); tick();
        // R1: reset state
        chk("R1 reset rd_data", rd_data, 12'h000);
        chk("R1 reset pulses", {3'b0, fifo_req, fifo_dir_wr, xfer_end_wr, xfer_end_rd,
            fifo_flush, force_tx_err, nak_irq, iso_in_irq, iso_out_irq}, 12'h000);
        rst_n = 1'b1; tick();
        chk("R3 idle token bit after reset", rd_data, 12'h400);

        // R5: sweep of all write values; only bits 9..3 follow the write
        for (int v = 0; v < 4096; v++) begin
            wr(v[11:0]);
            chk("R5 readback", rd_data, (v[11:0] & 12'h3F8) | 12'h400);
            chk("R5 fifo_req/dir", {10'b0, fifo_req, fifo_dir_wr}, {10'b0, v[8], v[7]});
        end
        breset();
        chk("R1 bus reset after sweep", rd_data, 12'h000);
        tick();

        // R3: read-only bits follow levels and ignore writes
        ev_tok_active = 1; ev_fifo_ready = 1; tick();
        chk("R3 token active / ready", rd_data & 12'h407, 12'h004);
        wr(12'h403);
        chk("R3 write ignored on RO bits", rd_data & 12'h407, 12'h004);
        ev_tok_active = 0; ev_fifo_ready = 0; tick();
        chk("R3 levels released", rd_data & 12'h407, 12'h400);

        // R2: sticky error flag
        ev_err = 1; tick(); ev_err = 0;
        chk("R2 set", {11'b0, rd_data[11]}, 12'h001);
        wr(12'h800); tick();
        chk("R2 write one keeps", {11'b0, rd_data[11]}, 12'h001);
        wr(12'h000);
        chk("R2 write zero clears", {11'b0, rd_data[11]}, 12'h000);
        wr(12'h800);
        chk("R2 write one does not set", {11'b0, rd_data[11]}, 12'h000);
        ev_err = 1; wr(12'h000); ev_err = 0;
        chk("R2 set beats clear", {11'b0, rd_data[11]}, 12'h001);
        wr(12'h000);

        // R4: NAK interrupt masking
        for (int m = 0; m < 2; m++) begin
            wr(12'(m) << 9);
            ev_nak_sent = 1; tick(); ev_nak_sent = 0;
            chk("R4 nak_irq", {11'b0, nak_irq}, {11'b0, !m[0]});
            tick();
            chk("R4 nak_irq single pulse", {11'b0, nak_irq}, 12'h000);
        end

        // R9: isochronous interrupt gating, all enable/event combinations
        for (int en = 0; en < 4; en++) begin
            wr(12'(en) << 4);
            for (int ev = 0; ev < 4; ev++) begin
                ev_iso_in = ev[1]; ev_iso_out = ev[0]; tick();
                ev_iso_in = 0; ev_iso_out = 0;
                chk("R9 iso irqs", {10'b0, iso_in_irq, iso_out_irq},
                    {10'b0, ev[1] & en[1], ev[0] & en[0]});
            end
        end
        wr(12'h000);

        // R6 / R7: transfer end over claim, old dir, new dir
        for (int c = 0; c < 8; c++) begin
            wr({3'b0, c[2], c[1], 7'b0});
            wr({3'b0, c[2], c[0], 7'b0});
            chk("R6 write end", {11'b0, xfer_end_wr}, {11'b0, c[2] & c[1] & !c[0]});
            chk("R7 read end", {11'b0, xfer_end_rd}, {11'b0, c[2] & !c[1] & c[0]});
            tick();
            chk("R6 R7 single pulse", {10'b0, xfer_end_wr, xfer_end_rd}, 12'h000);
        end

        // R8: flush and under-run reporting
        breset(); tick();
        host_in_req = 1; tick(); host_in_req = 0;
        chk("R8 no under-run before flush", {11'b0, force_tx_err}, 12'h000);
        wr(12'h040);
        chk("R8 flush pulse", {11'b0, fifo_flush}, 12'h001);
        wr(12'h040);
        chk("R8 no flush while bit held", {11'b0, fifo_flush}, 12'h000);
        host_in_req = 1; tick(); host_in_req = 0;
        chk("R8 forced tx error", {11'b0, force_tx_err}, 12'h001);
        wr(12'h180); wr(12'h100);
        chk("R8 refill write end", {11'b0, xfer_end_wr}, 12'h001);
        host_in_req = 1; tick(); host_in_req = 0;
        chk("R8 under-run disarmed", {11'b0, force_tx_err}, 12'h000);
        wr(12'h000);

        // R10: setup marker
        ev_setup_rx = 1; tick(); ev_setup_rx = 0;
        chk("R10 set", {11'b0, rd_data[3]}, 12'h001);
        tick();
        chk("R10 hold", {11'b0, rd_data[3]}, 12'h001);
        ev_data_rx = 1; tick(); ev_data_rx = 0;
        chk("R10 cleared by data", {11'b0, rd_data[3]}, 12'h000);
        ev_setup_rx = 1; ev_data_rx = 1; tick(); ev_setup_rx = 0; ev_data_rx = 0;
        chk("R10 setup beats data", {11'b0, rd_data[3]}, 12'h001);
        ev_data_rx = 1; wr(12'h008); ev_data_rx = 0;
        chk("R10 data beats write", {11'b0, rd_data[3]}, 12'h000);

        // R11: zero-length marker
        ev_zlp_rx = 1; tick(); ev_zlp_rx = 0;
        chk("R11 set", {11'b0, rd_data[1]}, 12'h001);
        wr(12'h000);
        chk("R11 write ignored", {11'b0, rd_data[1]}, 12'h001);
        fifo_rd = 1; tick(); fifo_rd = 0;
        chk("R11 cleared by read", {11'b0, rd_data[1]}, 12'h000);
        ev_zlp_rx = 1; fifo_rd = 1; tick(); ev_zlp_rx = 0; fifo_rd = 0;
        chk("R11 set beats read", {11'b0, rd_data[1]}, 12'h001);

        // R1: bus reset with state populated
        wr(12'h3F8); ev_err = 1; tick(); ev_err = 0;
        breset();
        chk("R1 bus reset clears all", rd_data, 12'h000);

        tick();
        finish_run();
    end
endmodule